// File: doc/BRIEF.md
# Audio Port Event Flag and Interrupt Unit

This block collects the events of a serial audio port into a status word and raises one interrupt line. The transmit and receive data paths send it single-cycle event pulses: end of transfer, transfer filled, underrun (transmit side), overrun (receive side), CRC error, frame error, mode fault, reload complete and suspended. Each pulse sets a sticky flag. The flag stays set until software writes a one to the matching bit of a separate clear register. Three packet-ready flags do not latch. They are computed every cycle from the FIFO fill levels and a programmable packet threshold, and they change as the levels change.

Software reaches the block through a small register port. The port has four word locations: status (read-only), interrupt enable, flag clear (write-one-to-clear, reads as zero) and configuration, which holds the threshold. The interrupt line is high while any status flag in bits 10:0 is set together with its enable bit. Read data is combinational on the address. A write takes effect at the next rising clock edge.

Top module: `audio_port_irq_unit`

## Requirements
- R1: After reset the sticky flags, the enable register and the threshold are all zero, and `irq_o` is low.
- R2: A pulse on `ev_pulse_i[k]` (k = 0..8) sets status bit k+3 at the next clock edge. The bit stays set until it is cleared. Status bit order is: 3 end of transfer, 4 transfer filled, 5 underrun, 6 overrun, 7 CRC error, 8 frame error, 9 mode fault, 10 reload complete, 11 suspended.
- R3: A write to the clear register (address 2) with a one in bit b (3 ≤ b ≤ 11) clears status bit b. Zero bits have no effect. Bits outside 11:3 are ignored. The clear register reads as zero.
- R4: When an event pulse and a clear for the same flag arrive in the same cycle, the flag ends up set.
- R5: A frame-error pulse (`ev_pulse_i[5]`) sets status bit 8 only while `clk_slave_i` is high. Otherwise the pulse is ignored.
- R6: The enable register (address 1) holds bits 10:0, which line up with status bits 10:0. Its bits 31:11 read as zero. `irq_o` is high exactly when (status[10:0] & enable[10:0]) is non-zero.
- R7: Status bit 0 (receive packet ready) is high while `rx_level_i` ≥ threshold+1.
- R8: Status bit 1 (transmit packet ready) is high while FIFO_DEPTH − `tx_level_i` ≥ threshold+1. The default FIFO_DEPTH is 16.
- R9: Status bit 2 (duplex packet ready) is high while both bit 0 and bit 1 are high.
- R10: The configuration register (address 3) holds the threshold in bits 8:5. The threshold is coded as packet size minus one, so a quarter of a 16-entry FIFO is written as 3. All other bits of this register read as zero.
- R11: Status bit 12 follows `tx_done_i`, bits 14:13 follow `rx_pack_lvl_i` and bit 15 follows `rx_word_ne_i`, all in the same cycle. Bits 31:16 read as zero.
- R12: Writes to the status address (0) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word select: 0 status, 1 enable, 2 clear, 3 config |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| ev_pulse_i | input | 9 | Event pulses, bit k sets status bit k+3 |
| clk_slave_i | input | 1 | Port runs as clock slave (enables frame error) |
| rx_level_i | input | 5 | Receive FIFO fill level |
| tx_level_i | input | 5 | Transmit FIFO fill level |
| tx_done_i | input | 1 | Transmission complete (live) |
| rx_pack_lvl_i | input | 2 | Receive packing level (live) |
| rx_word_ne_i | input | 1 | Receive word not empty (live) |
| irq_o | output | 1 | Interrupt request |

## Verification
Single pulses on each event line show that every flag maps to its own status bit. Clear writes with mixed masks and stray high bits show that only bits 11:3 clear flags, and that a zero bit leaves its flag alone. A pulse and a clear arriving together on one flag shows the set-wins priority. The frame-error pulse is applied with the slave input both low and high. FIFO levels are swept across the threshold edges (one below, equal, one above) for several threshold codes, which exposes off-by-one errors in the packet-ready comparisons. A long random run mixes enables, pulses and clears, and compares the interrupt line against the model every cycle.

// File: rtl/apiu_pkg.sv
package apiu_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned STK_LO    = 3;
  localparam int unsigned STK_HI    = 11;
  localparam int unsigned N_STK     = STK_HI - STK_LO + 1;
  localparam int unsigned FRAME_IDX = 8 - STK_LO;
  localparam int unsigned EN_W      = 11;
  localparam int unsigned THR_LSB   = 5;
  localparam int unsigned THR_W     = 4;

  typedef enum logic [1:0] {
    ADDR_STAT = 2'd0,
    ADDR_EN   = 2'd1,
    ADDR_CLR  = 2'd2,
    ADDR_CFG  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/apiu_flag_bank.sv
module apiu_flag_bank #(
  parameter int unsigned N        = 9,
  parameter int unsigned GATE_IDX = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         gate_en_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;
  logic [N-1:0] set_eff;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == GATE_IDX) begin : g_gated
      assign set_eff[i] = set_i[i] & gate_en_i;
    end else begin : g_plain
      assign set_eff[i] = set_i[i];
    end

    always_comb begin
      flag_d[i] = flag_q[i];
      if (clr_i[i])   flag_d[i] = 1'b0;
      if (set_eff[i]) flag_d[i] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else if (set_eff[i] | clr_i[i]) flag_q[i] <= flag_d[i];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/apiu_level_cmp.sv
module apiu_level_cmp #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = 5,
  parameter int unsigned THR_W = 4
) (
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             rx_rdy_o,
  output logic             tx_rdy_o,
  output logic             dup_rdy_o
);
  localparam int unsigned CW = ((LVL_W > THR_W) ? LVL_W : THR_W) + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] pkt;
  logic [CW-1:0] tx_free;

  always_comb begin
    pkt       = CW'(thr_i) + CW'(1);
    tx_free   = DEPTH_C - CW'(tx_level_i);
    rx_rdy_o  = CW'(rx_level_i) >= pkt;
    tx_rdy_o  = (CW'(tx_level_i) <= DEPTH_C) && (tx_free >= pkt);
    dup_rdy_o = rx_rdy_o & tx_rdy_o;
  end
endmodule

// File: rtl/apiu_regfile.sv
module apiu_regfile
  import apiu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [EN_W-1:0]   en_o,
  output logic [THR_W-1:0]  thr_o,
  output logic [N_STK-1:0]  clr_o
);
  logic [EN_W-1:0]  en_q,  en_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic             en_ce, thr_ce;

  always_comb begin
    en_ce  = we_i && (addr_i == ADDR_EN);
    thr_ce = we_i && (addr_i == ADDR_CFG);
    en_d   = wdata_i[EN_W-1:0];
    thr_d  = wdata_i[THR_LSB +: THR_W];
    clr_o  = (we_i && (addr_i == ADDR_CLR)) ? wdata_i[STK_HI:STK_LO] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_q <= '0;
    else if (thr_ce) thr_q <= thr_d;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_STAT: rdata_o = status_i;
      ADDR_EN:   rdata_o[EN_W-1:0] = en_q;
      ADDR_CLR:  rdata_o = '0;
      ADDR_CFG:  rdata_o[THR_LSB +: THR_W] = thr_q;
      default:   rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign thr_o = thr_q;
endmodule

// File: rtl/audio_port_irq_unit.sv
module audio_port_irq_unit
  import apiu_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [N_STK-1:0]  ev_pulse_i,
  input  logic              clk_slave_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic              tx_done_i,
  input  logic [1:0]        rx_pack_lvl_i,
  input  logic              rx_word_ne_i,
  output logic              irq_o
);
  logic [N_STK-1:0]  sticky;
  logic [N_STK-1:0]  clr_vec;
  logic [EN_W-1:0]   en_q;
  logic [THR_W-1:0]  thr_q;
  logic              rx_rdy, tx_rdy, dup_rdy;
  logic [DATA_W-1:0] status_w;

  apiu_flag_bank #(.N(N_STK), .GATE_IDX(FRAME_IDX)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ev_pulse_i),
    .clr_i     (clr_vec),
    .gate_en_i (clk_slave_i),
    .flag_o    (sticky)
  );

  apiu_level_cmp #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .THR_W(THR_W)) u_lvl (
    .rx_level_i (rx_level_i),
    .tx_level_i (tx_level_i),
    .thr_i      (thr_q),
    .rx_rdy_o   (rx_rdy),
    .tx_rdy_o   (tx_rdy),
    .dup_rdy_o  (dup_rdy)
  );

  always_comb begin
    status_w                 = '0;
    status_w[0]              = rx_rdy;
    status_w[1]              = tx_rdy;
    status_w[2]              = dup_rdy;
    status_w[STK_HI:STK_LO]  = sticky;
    status_w[12]             = tx_done_i;
    status_w[14:13]          = rx_pack_lvl_i;
    status_w[15]             = rx_word_ne_i;
  end

  apiu_regfile u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status_w),
    .rdata_o  (reg_rdata_o),
    .en_o     (en_q),
    .thr_o    (thr_q),
    .clr_o    (clr_vec)
  );

  assign irq_o = |(status_w[EN_W-1:0] & en_q);
endmodule

// File: rtl/audio_port_irq_chk.sv
module audio_port_irq_chk
  import apiu_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [N_STK-1:0]  ev_pulse_i,
  input logic              clk_slave_i,
  input logic [LVL_W-1:0]  rx_level_i,
  input logic [DATA_W-1:0] status_w,
  input logic [EN_W-1:0]   en_q,
  input logic [THR_W-1:0]  thr_q,
  input logic              irq_o
);
  logic clr_wr;
  assign clr_wr = reg_we_i && (reg_addr_i == ADDR_CLR);

  // R2
  ev_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_pulse_i[0] || ev_pulse_i[8]) |=> (status_w[3] || !$past(ev_pulse_i[0]))
                                       && (status_w[11] || !$past(ev_pulse_i[8])));

  // R4
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && reg_wdata_i[6] && ev_pulse_i[3]) |=> status_w[6]);

  // R3
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && ev_pulse_i == '0) |=>
      ((status_w[STK_HI:STK_LO] & $past(reg_wdata_i[STK_HI:STK_LO])) == '0));

  // R2
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_wr && ev_pulse_i == '0) |=> $stable(status_w[STK_HI:STK_LO]));

  // R5
  frame_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_slave_i && !status_w[8] && !(clr_wr && 1'b0)) |=> !status_w[8]);

  // R6
  irq_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(status_w[EN_W-1:0] & en_q)));

  // R7
  rx_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_w[0] == ({1'b0, rx_level_i} > {{(LVL_W+1-THR_W){1'b0}}, thr_q}));
endmodule

bind audio_port_irq_unit audio_port_irq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .ev_pulse_i  (ev_pulse_i),
  .clk_slave_i (clk_slave_i),
  .rx_level_i  (rx_level_i),
  .status_w    (status_w),
  .en_q        (en_q),
  .thr_q       (thr_q),
  .irq_o       (irq_o)
);

// File: tb/audio_port_irq_unit_tb.sv
module audio_port_irq_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        reg_we_i;
  logic [1:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic [8:0]  ev_pulse_i;
  logic        clk_slave_i;
  logic [4:0]  rx_level_i;
  logic [4:0]  tx_level_i;
  logic        tx_done_i;
  logic [1:0]  rx_pack_lvl_i;
  logic        rx_word_ne_i;
  logic        irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [8:0]  m_stk;
  logic [10:0] m_en;
  logic [3:0]  m_thr;

  always #2 clk_i = ~clk_i;

  audio_port_irq_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .ev_pulse_i(ev_pulse_i),
    .clk_slave_i(clk_slave_i), .rx_level_i(rx_level_i), .tx_level_i(tx_level_i),
    .tx_done_i(tx_done_i), .rx_pack_lvl_i(rx_pack_lvl_i), .rx_word_ne_i(rx_word_ne_i),
    .irq_o(irq_o)
  );

  function automatic logic [31:0] model_status();
    logic [31:0] s;
    int pkt;
    logic rr, tr;
    pkt = int'(m_thr) + 1;
    rr = int'(rx_level_i) >= pkt;
    tr = (16 - int'(tx_level_i)) >= pkt;
    s = '0;
    s[0] = rr; s[1] = tr; s[2] = rr & tr;
    s[11:3] = m_stk;
    s[12] = tx_done_i; s[14:13] = rx_pack_lvl_i; s[15] = rx_word_ne_i;
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, reg_addr_i, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [1:0] addr,
                      input logic [31:0] wd, input logic [8:0] ev, input logic slv,
                      input int rxl, input int txl, input logic txc,
                      input logic [1:0] pk, input logic rne);
    logic [31:0] st, exp_rd;
    reg_we_i = we; reg_addr_i = addr; reg_wdata_i = wd; ev_pulse_i = ev;
    clk_slave_i = slv; rx_level_i = 5'(rxl); tx_level_i = 5'(txl);
    tx_done_i = txc; rx_pack_lvl_i = pk; rx_word_ne_i = rne;
    #1;
    st = model_status();
    case (addr)
      2'd0: exp_rd = st;
      2'd1: exp_rd = {21'b0, m_en};
      2'd2: exp_rd = '0;
      default: exp_rd = {23'b0, m_thr, 5'b0};
    endcase
    check(tag, reg_rdata_o, exp_rd);
    check("R6 irq", {31'b0, irq_o}, {31'b0, |(st[10:0] & m_en)});
    @(posedge clk_i);
    if (we && addr == 2'd1) m_en = wd[10:0];
    if (we && addr == 2'd3) m_thr = wd[8:5];
    m_stk = (m_stk & ~((we && addr == 2'd2) ? wd[11:3] : 9'b0)) | (ev & {~slv ? 1'b0 : 1'b1, 5'b11111} == 0 ? 9'b0 : (ev & {3'b111, slv, 5'b11111}));
    @(negedge clk_i);
  endtask

  task automatic rd(input string tag, input logic [1:0] addr);
    step(tag, 1'b0, addr, '0, '0, 1'b0, 0, 16, 1'b0, 2'b00, 1'b0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_stk = '0; m_en = '0; m_thr = '0;
    rst_ni = 1'b0; reg_we_i = 0; reg_addr_i = 0; reg_wdata_i = 0; ev_pulse_i = 0;
    clk_slave_i = 0; rx_level_i = 0; tx_level_i = 16; tx_done_i = 0;
    rx_pack_lvl_i = 0; rx_word_ne_i = 0;
    #5;
    check("R1 reset status", reg_rdata_o, 32'h0);
    check("R1 reset irq", {31'b0, irq_o}, 32'h0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd("R1 enable", 2'd1);
    rd("R10 cfg", 2'd3);
    rd("R1 status", 2'd0);

    // R2: each event alone
    for (int k = 0; k < 9; k++) begin
      step("R2 pulse", 0, 2'd0, 0, 9'(1 << k), 1'b1, 0, 16, 0, 0, 0);
      rd("R2 sticky", 2'd0);
    end
    // R3: clear with mixed masks and stray bits
    step("R3 clr", 1, 2'd2, 32'hFFFF_F007 | (32'h0A8 << 3) & ~32'h0, 0, 1, 0, 16, 0, 0, 0);
    rd("R3 partial", 2'd0);
    rd("R3 clr reads 0", 2'd2);
    step("R3 zero write", 1, 2'd2, 32'h0, 0, 1, 0, 16, 0, 0, 0);
    rd("R3 unchanged", 2'd0);
    step("R3 clr all", 1, 2'd2, 32'h0000_0FF8, 0, 1, 0, 16, 0, 0, 0);
    rd("R3 all clear", 2'd0);
    // R4
    step("R4 set+clr", 1, 2'd2, 32'h0000_0FF8, 9'b000001000, 1, 0, 16, 0, 0, 0);
    rd("R4 set wins", 2'd0);
    // R5
    step("R3 clr", 1, 2'd2, 32'h0000_0FF8, 0, 0, 0, 16, 0, 0, 0);
    step("R5 master frame", 0, 2'd0, 0, 9'b000100000, 0, 0, 16, 0, 0, 0);
    rd("R5 ignored", 2'd0);
    step("R5 slave frame", 0, 2'd0, 0, 9'b000100000, 1, 0, 16, 0, 0, 0);
    rd("R5 set", 2'd0);
    // R6
    step("R6 en write", 1, 2'd1, 32'hFFFF_FFFF, 0, 0, 0, 16, 0, 0, 0);
    rd("R6 en read", 2'd1);
    step("R6 en frame only", 1, 2'd1, 32'h0000_0100, 0, 0, 0, 16, 0, 0, 0);
    step("R6 en none", 1, 2'd1, 32'h0000_0020, 0, 0, 0, 16, 0, 0, 0);
    step("R6 udr", 0, 2'd0, 0, 9'b000000100, 0, 0, 16, 0, 0, 0);
    rd("R6 irq up", 2'd0);
    // R12
    step("R12 stat write", 1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0, 16, 0, 0, 0);
    rd("R12 no change", 2'd0);
    rd("R12 en kept", 2'd1);
    rd("R12 thr kept", 2'd3);
    // R7 R8 R9 R10 sweeps
    for (int t = 0; t < 16; t += 3) begin
      step("R10 thr", 1, 2'd3, 32'hFFFF_FE1F | (t << 5), 0, 0, 0, 16, 0, 0, 0);
      rd("R10 thr read", 2'd3);
      step("R7 below", 1, 2'd1, 32'h7, 0, 0, t, 16, 0, 0, 0);
      for (int d = -1; d <= 1; d++) begin
        step("R7 rx edge", 0, 2'd0, 0, 0, 0, t + 1 + d, 16, 0, 0, 0);
        step("R8 tx edge", 0, 2'd0, 0, 0, 0, 0, 15 - t - d, 0, 0, 0);
        step("R9 dup edge", 0, 2'd0, 0, 0, 0, t + 1 + d, 15 - t, 0, 0, 0);
      end
    end
    step("R10 quarter", 1, 2'd3, 32'd3 << 5, 0, 0, 4, 12, 0, 0, 0);
    rd("R9 quarter", 2'd0);
    // R11
    step("R11 live", 0, 2'd0, 0, 0, 0, 0, 16, 1, 2'b10, 1);
    step("R11 live", 0, 2'd0, 0, 0, 0, 0, 16, 0, 2'b01, 0);
    step("R11 live", 0, 2'd0, 0, 0, 0, 0, 16, 1, 2'b11, 1);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      step(a == 0 ? "R2 rand" : (a == 1 ? "R6 rand" : (a == 2 ? "R3 rand" : "R10 rand")),
           1'($urandom_range(0, 1)), a, $urandom, 9'($urandom) & 9'($urandom),
           1'($urandom_range(0, 1)), $urandom_range(0, 16), $urandom_range(0, 16),
           1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule